// File: doc/BRIEF.md
# Loadable Shift-Register Sequence Generator

This block produces a pseudo-random bit stream from a four-stage shift register. The stages are called QA, QB, QC and QD, with QA at the input end. A mode input picks between two behaviours. In load mode, each clock edge copies a four-bit seed into the stages. In shift mode, each edge moves every stage one place toward QD, and QA takes the exclusive-OR of QC and QD.

Once a non-zero seed is in place, the register steps through all fifteen non-zero states before it repeats one. The serial stream is read from QA. The all-zero state cannot start the cycle: shifting from it leaves the register at zero. Reset puts the register in the all-ones state, so the block generates a sequence without first being loaded.

The parallel state is brought out with QA in the most significant bit. The port order is {QA, QB, QC, QD}, so state_o[3] is QA and state_o[0] is QD.

Top module: `seq_gen_top`

## Requirements
- R1: While rst_n is low, and after it is released, state_o reads 4'b1111 and serial_o reads 1 until the first clock edge after release.
- R2: A rising clock edge with load_mode = 1 makes state_o equal to the value seed_i had at that edge, for any seed including 4'b0000.
- R3: A rising clock edge with load_mode = 0 moves the bits toward QD: new state_o[2:0] equals old state_o[3:1].
- R4: On a shift edge, the new QA (state_o[3]) equals old QC XOR old QD (state_o[1] ^ state_o[0]).
- R5: serial_o always equals QA (state_o[3]).
- R6: From any non-zero state, 15 consecutive shift edges visit 15 distinct non-zero states and return to the starting state.
- R7: From state 4'b0000, shift edges keep the state at 4'b0000.
- R8: A load edge replaces the current state regardless of where the sequence is. Shifting then continues from the loaded seed.
- R9: From 4'b1111, the first shift edges give 0111, 0011, 0001, 1000, 0100, 0010, 1001, 1100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to all ones |
| load_mode | input | 1 | 1 = load seed on the edge, 0 = shift on the edge |
| seed_i | input | 4 | Starting state {QA,QB,QC,QD} |
| state_o | output | 4 | Current state {QA,QB,QC,QD} |
| serial_o | output | 1 | Generated bit stream, equal to QA |

## Verification
A wrong feedback bit shows at serial_o on the very next shift edge. It then moves one position per edge across state_o, so it is visible within at most four cycles. A stage that is stuck or mis-wired breaks the fifteen-state cycle. The sweep over every non-zero seed catches this as a repeated state, or as a failure to return to the seed after exactly fifteen shifts. A faulty load path shows on the cycle after the load edge, because state_o no longer matches the seed.

// File: rtl/seq_gen_pkg.sv
package seq_gen_pkg;
   // Mode encoding on the load_mode pin
   typedef enum logic {
      MODE_SHIFT = 1'b0,
      MODE_LOAD  = 1'b1
   } seq_mode_e;

   localparam int unsigned SEQ_STAGES_DEF = 4;
endpackage

// File: rtl/seq_fb_xor.sv
module seq_fb_xor #(
   parameter int unsigned N_STAGES = 4,
   parameter int unsigned TAP_HI   = 1,   // QC position
   parameter int unsigned TAP_LO   = 0    // QD position
) (
   input  logic [N_STAGES-1:0] cur_state,
   output logic                fb_bit
);
   if (TAP_HI >= N_STAGES || TAP_LO >= N_STAGES) begin : g_bad_tap
      $error("seq_fb_xor: tap index outside the register");
   end
   if (TAP_HI == TAP_LO) begin : g_same_tap
      $error("seq_fb_xor: taps must differ");
   end

   always_comb begin
      fb_bit = cur_state[TAP_HI] ^ cur_state[TAP_LO];
   end
endmodule

// File: rtl/seq_shift_chain.sv
module seq_shift_chain
   import seq_gen_pkg::*;
#(
   parameter int unsigned       N_STAGES = 4,
   parameter logic [N_STAGES-1:0] RST_VAL = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_en,
   input  logic [N_STAGES-1:0] seed,
   input  logic                fb_in,
   output logic [N_STAGES-1:0] q
);
   localparam int unsigned HEAD = N_STAGES - 1;

   if (N_STAGES < 2) begin : g_bad_len
      $error("seq_shift_chain: at least two stages needed");
   end

   logic [N_STAGES-1:0] nxt;

   for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
      if (i == HEAD) begin : g_head
         always_comb nxt[i] = (load_en == MODE_LOAD) ? seed[i] : fb_in;
      end else begin : g_body
         always_comb nxt[i] = (load_en == MODE_LOAD) ? seed[i] : q[i+1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= RST_VAL[i];
         else        q[i] <= nxt[i];
      end
   end

   // R2: a load edge captures the seed
   p_load_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> q == $past(seed));

   // R3: a shift edge moves every stage one place away from the head
   p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !load_en |=> q[HEAD-1:0] == $past(q[HEAD:1]));
endmodule

// File: rtl/seq_gen_top.sv
module seq_gen_top
   import seq_gen_pkg::*;
#(
   parameter int unsigned       N_STAGES = SEQ_STAGES_DEF,
   parameter int unsigned       TAP_HI   = 1,
   parameter int unsigned       TAP_LO   = 0,
   parameter logic [N_STAGES-1:0] RST_VAL = '1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_mode,
   input  logic [N_STAGES-1:0] seed_i,
   output logic [N_STAGES-1:0] state_o,
   output logic                serial_o
);
   localparam int unsigned HEAD = N_STAGES - 1;

   if (RST_VAL == '0) begin : g_bad_rst
      $error("seq_gen_top: reset value must be non-zero");
   end

   logic fb;
   logic [N_STAGES-1:0] st;

   seq_fb_xor #(
      .N_STAGES (N_STAGES),
      .TAP_HI   (TAP_HI),
      .TAP_LO   (TAP_LO)
   ) u_fb (
      .cur_state (st),
      .fb_bit    (fb)
   );

   seq_shift_chain #(
      .N_STAGES (N_STAGES),
      .RST_VAL  (RST_VAL)
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (load_mode),
      .seed    (seed_i),
      .fb_in   (fb),
      .q       (st)
   );

   assign state_o  = st;
   assign serial_o = st[HEAD];

   // R4: the head stage takes the tap XOR of the previous state
   p_feedback_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !load_mode |=> st[HEAD] == ($past(st[TAP_HI]) ^ $past(st[TAP_LO])));

   // R5: the serial bit after a shift reflects the taps one edge earlier
   p_serial_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_mode |=> serial_o == $past(st[TAP_HI] ^ st[TAP_LO]));

   // R6: shifting never leaves the non-zero set
   p_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_mode && st != '0) |=> st != '0);

   // R7: the zero state is a fixed point under shifting
   p_zero_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_mode && st == '0) |=> st == '0);
endmodule

// File: tb/seq_gen_top_bench.sv
module seq_gen_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_mode = 1'b0;
   logic [3:0] seed_i = 4'h0;
   logic [3:0] state_o;
   logic       serial_o;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   seq_gen_top u_seq_gen_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_mode (load_mode),
      .seed_i    (seed_i),
      .state_o   (state_o),
      .serial_o  (serial_o)
   );

   task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %b expected %b", req, act, exp);
      end
   endtask

   // expected successor: QA gets QC^QD, the rest move toward QD
   function automatic logic [3:0] succ(input logic [3:0] s);
      return {s[1] ^ s[0], s[3], s[2], s[1]};
   endfunction

   // drive at negedge, let one posedge pass, sample at the following negedge
   task automatic edge_with(input logic ld, input logic [3:0] sd);
      load_mode = ld;
      seed_i    = sd;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual %b expected %b", 4'h0, 4'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [3:0] exp_s;
      logic [15:0] seen;
      @(negedge clk);
      chk(state_o == 4'b1111, "R1 in reset", state_o, 4'b1111);
      rst_n = 1'b1;
      #1;
      chk(state_o == 4'b1111, "R1 after release", state_o, 4'b1111);
      chk(serial_o == 1'b1, "R1 serial", {3'b0, serial_o}, 4'b0001);

      // R9: listed sequence from all ones (reset state)
      begin
         logic [3:0] tbl [8] = '{4'b0111, 4'b0011, 4'b0001, 4'b1000,
                                4'b0100, 4'b0010, 4'b1001, 4'b1100};
         for (int k = 0; k < 8; k++) begin
            edge_with(1'b0, 4'hA);
            chk(state_o == tbl[k], "R9 sequence", state_o, tbl[k]);
         end
      end

      // R2/R3/R4/R5/R6: sweep every non-zero seed
      for (int sd = 1; sd < 16; sd++) begin
         edge_with(1'b1, sd[3:0]);
         chk(state_o == sd[3:0], "R2 load", state_o, sd[3:0]);
         exp_s = sd[3:0];
         seen  = '0;
         for (int k = 0; k < 15; k++) begin
            edge_with(1'b0, ~sd[3:0]);
            exp_s = succ(exp_s);
            chk(state_o[2:0] == exp_s[2:0], "R3 shift", state_o, exp_s);
            chk(state_o[3] == exp_s[3], "R4 feedback", state_o, exp_s);
            chk(serial_o == state_o[3], "R5 serial", {3'b0, serial_o}, {3'b0, state_o[3]});
            chk(state_o != 4'h0 && !seen[state_o], "R6 distinct", state_o, exp_s);
            seen[state_o] = 1'b1;
         end
         chk(state_o == sd[3:0], "R6 period 15", state_o, sd[3:0]);
      end

      // R7: zero locks
      edge_with(1'b1, 4'h0);
      chk(state_o == 4'h0, "R2 load zero", state_o, 4'h0);
      for (int k = 0; k < 5; k++) begin
         edge_with(1'b0, 4'hF);
         chk(state_o == 4'h0, "R7 zero lock", state_o, 4'h0);
      end

      // R8: reload mid-sequence, then resume from the new seed
      edge_with(1'b1, 4'b1111);
      edge_with(1'b0, 4'h0);
      edge_with(1'b0, 4'h0);
      edge_with(1'b1, 4'b0110);
      chk(state_o == 4'b0110, "R8 reload", state_o, 4'b0110);
      edge_with(1'b0, 4'h0);
      chk(state_o == succ(4'b0110), "R8 resume", state_o, succ(4'b0110));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule